// File: doc/BRIEF.md
# DMA Address Table Walker

This block turns a device DMA address into a physical address. It walks up to three levels of translation tables held in memory: a region table, then a segment table, then a page table. A request carries the DMA address, the table-origin register and an access code. The walker first compares the address against a base/limit window. It then issues one 64-bit read per level on a simple memory read port. It returns the translated address, the log2 of the frame size it resolved, a two-bit permission and an error code.

Permission starts at read/write, or at read-only when the origin register is protected. A protected entry at any level narrows it further. Nothing widens it again. The walk can end early at the segment level when that entry maps a large frame. An all-zero entry and a present-but-invalid entry are reported differently: the first is a fault, the second only withdraws permission.

Top module: `dma_xlate_walker`

## Requirements
- R1: After reset `req_ready_o` is 1 and `rsp_valid_o` and `mem_req_o` are 0. A request is taken only while `req_ready_o` is 1, which holds only while idle. Each request yields exactly one single-cycle `rsp_valid_o` pulse.
- R2: A DMA address below `win_base_i` or above `win_limit_i` gives error code 1 (out of range), permission 0, address 0 and length code 0. No memory read is made, and the response comes in the cycle after acceptance. Both window bounds are inclusive.
- R3: Levels are read in the order region, segment, page, with at most three reads per request. The region index is DMA address bits [41:31], the segment index bits [30:20] and the page index bits [19:12]. Each entry address is the current table origin, with bits [11:0] cleared, plus index times 8. The first origin comes from bits [63:12] of `req_origin_i`, and later origins come from bits [63:12] of the entry just read.
- R4: An entry read as all zeros ends the walk with error code 2, permission 0 and address 0.
- R5: A nonzero entry whose valid bit (bit 4) is 0 ends the walk with permission 0 and address 0. For a probe access the error code is 0.
- R6: A region entry whose length field [1:0] is not 3, or whose offset field [7:6] is not 0, ends the walk with error code 3 and permission 0.
- R7: A table-type field [3:2] that does not match the level ends the walk with error code 4 and permission 0. Region entries must hold 3 there and segment entries 2; page entries are not checked. An entry whose bits [63:12] are all zero gets the same result, at any level.
- R8: The protect bit (bit 9), in the origin register or in any entry that passes the checks, limits permission to read-only. Permission bit 0 is read and bit 1 is write; a successful unprotected walk gives 3.
- R9: A segment entry with bit 10 set completes the walk after two reads. Its address is entry bits [63:20] joined with DMA address bits [19:0]. A page entry completes the walk with entry bits [63:12] joined with DMA address bits [11:0].
- R10: The length code is the log2 of the frame size of the last level read: 31 for region, 20 for segment and 12 for page. This holds also when that level ended the walk with a fault or an invalid entry.
- R11: The access code is 0 for probe, 1 for read and 2 for write. When no fault occurred and the final permission lacks the bit the access needs, the error code becomes 5. A probe never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Walker idle, request taken |
| req_iova_i | input | 64 | DMA address to translate |
| req_origin_i | input | 64 | Table-origin register: origin in [63:12], protect in bit 9 |
| req_acc_i | input | 2 | Access code: 0 probe, 1 read, 2 write |
| win_base_i | input | 64 | Lowest DMA address accepted |
| win_limit_i | input | 64 | Highest DMA address accepted |
| mem_req_o | output | 1 | Entry read request, one cycle |
| mem_addr_o | output | 64 | Byte address of the entry |
| mem_rvalid_i | input | 1 | Entry data valid |
| mem_rdata_i | input | 64 | Entry data |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_addr_o | output | 64 | Translated physical address |
| rsp_len_o | output | 6 | Log2 of resolved frame size |
| rsp_perm_o | output | 2 | Permission: bit 0 read, bit 1 write |
| rsp_err_o | output | 3 | Error code, 0 when none |

## Verification
The properties take for granted three things about the memory: it returns exactly one `mem_rvalid_i` for each `mem_req_o`, the answer comes at least one cycle later, and it never arrives while the walker is idle. They also assume the access code is never 3 and that request fields matter only in the acceptance cycle. The bench keeps to this with a responder that answers every read on the following cycle from a sparse memory. It holds `req_valid_i` for one cycle only, and it sweeps just the codes 0 to 2. Each table level is swept through zero, invalid, malformed, protected and good entries, with and without a protected origin. Window edges are tested at one address on each side of both bounds.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam int unsigned WORD_W = 64;
  localparam int unsigned ORG_SH = 12;
  // entry field positions
  localparam int unsigned E_LEN_LO  = 0;
  localparam int unsigned E_TYPE_LO = 2;
  localparam int unsigned E_VALID   = 4;
  localparam int unsigned E_OFS_LO  = 6;
  localparam int unsigned E_PROT    = 9;
  localparam int unsigned E_FC      = 10;

  localparam logic [1:0] TYPE_REG = 2'b11;
  localparam logic [1:0] TYPE_SEG = 2'b10;
  localparam logic [1:0] LEN_FULL = 2'b11;

  localparam logic [1:0] ACC_READ = 2'd1;
  localparam logic [1:0] PERM_RW   = 2'b11;
  localparam logic [1:0] PERM_RO   = 2'b01;
  localparam logic [1:0] PERM_NONE = 2'b00;

  typedef enum logic [1:0] {LVL_REG, LVL_SEG, LVL_PAGE} lvl_e;
  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_RANGE = 3'd1,
    ERR_ENTRY = 3'd2,
    ERR_TLEN  = 3'd3,
    ERR_TTYPE = 3'd4,
    ERR_PROT  = 3'd5
  } err_e;
  typedef enum logic [1:0] {OUT_NEXT, OUT_DONE, OUT_STOP, OUT_FAULT} out_e;

  typedef struct packed {
    out_e              kind;
    err_e              err;
    logic              prot;
    logic [WORD_W-1:0] nto;
    logic [WORD_W-1:0] addr;
  } eval_t;
endpackage

// File: rtl/xw_range_chk.sv
module xw_range_chk
  import xw_pkg::*;
(
  input  logic [WORD_W-1:0] iova_i,
  input  logic [WORD_W-1:0] base_i,
  input  logic [WORD_W-1:0] limit_i,
  output logic              oor_o
);
  assign oor_o = (iova_i < base_i) || (iova_i > limit_i);
endmodule

// File: rtl/xw_index_gen.sv
module xw_index_gen
  import xw_pkg::*;
#(
  parameter int unsigned RX_W = 11,
  parameter int unsigned SX_W = 11,
  parameter int unsigned PX_W = 8,
  localparam int unsigned HI_W = RX_W + SX_W + PX_W
) (
  input  lvl_e              lvl_i,
  input  logic [WORD_W-1:0] origin_i,
  input  logic [HI_W-1:0]   iova_hi_i,
  output logic [WORD_W-1:0] addr_o
);
  logic [WORD_W-1:0] idx;

  always_comb begin
    case (lvl_i)
      LVL_REG: idx = WORD_W'(iova_hi_i[PX_W+SX_W +: RX_W]);
      LVL_SEG: idx = WORD_W'(iova_hi_i[PX_W +: SX_W]);
      default: idx = WORD_W'(iova_hi_i[0 +: PX_W]);
    endcase
  end

  assign addr_o = origin_i + (idx << 3);
endmodule

// File: rtl/xw_entry_eval.sv
module xw_entry_eval
  import xw_pkg::*;
#(
  parameter int unsigned PAGE_SH = 12,
  parameter int unsigned SEG_SH  = 20
) (
  input  lvl_e              lvl_i,
  input  logic [WORD_W-1:0] entry_i,
  input  logic [SEG_SH-1:0] low_i,
  output eval_t             res_o
);
  logic type_ok;
  logic len_bad;

  always_comb begin
    case (lvl_i)
      LVL_REG: type_ok = entry_i[E_TYPE_LO +: 2] == TYPE_REG;
      LVL_SEG: type_ok = entry_i[E_TYPE_LO +: 2] == TYPE_SEG;
      default: type_ok = 1'b1;
    endcase
  end

  assign len_bad = (lvl_i == LVL_REG) &&
                   ((entry_i[E_LEN_LO +: 2] != LEN_FULL) || (entry_i[E_OFS_LO +: 2] != 2'b00));

  always_comb begin
    res_o      = '0;
    res_o.kind = OUT_NEXT;
    res_o.err  = ERR_NONE;
    res_o.prot = entry_i[E_PROT];
    res_o.nto  = {entry_i[WORD_W-1:ORG_SH], {ORG_SH{1'b0}}};
    if (entry_i == '0) begin
      res_o.kind = OUT_FAULT;
      res_o.err  = ERR_ENTRY;
    end else if (!entry_i[E_VALID]) begin
      res_o.kind = OUT_STOP;
    end else if (len_bad) begin
      res_o.kind = OUT_FAULT;
      res_o.err  = ERR_TLEN;
    end else if (!type_ok || (res_o.nto == '0)) begin
      res_o.kind = OUT_FAULT;
      res_o.err  = ERR_TTYPE;
    end else if (lvl_i == LVL_PAGE) begin
      res_o.kind = OUT_DONE;
      res_o.addr = {entry_i[WORD_W-1:PAGE_SH], low_i[PAGE_SH-1:0]};
    end else if ((lvl_i == LVL_SEG) && entry_i[E_FC]) begin
      res_o.kind = OUT_DONE;
      res_o.addr = {entry_i[WORD_W-1:SEG_SH], low_i};
    end
  end
endmodule

// File: rtl/xw_access_chk.sv
module xw_access_chk
  import xw_pkg::*;
(
  input  logic [1:0] acc_i,
  input  logic [1:0] perm_i,
  output logic       viol_o
);
  assign viol_o = ((acc_i == ACC_READ) && !perm_i[0]) || (acc_i[1] && !perm_i[1]);
endmodule

// File: rtl/dma_xlate_walker.sv
module dma_xlate_walker
  import xw_pkg::*;
#(
  parameter int unsigned RX_W    = 11,
  parameter int unsigned SX_W    = 11,
  parameter int unsigned PX_W    = 8,
  parameter int unsigned PAGE_SH = 12,
  localparam int unsigned SEG_SH = PAGE_SH + PX_W,
  localparam int unsigned REG_SH = SEG_SH + SX_W,
  localparam int unsigned IOVA_W = REG_SH + RX_W,
  localparam int unsigned LEN_W  = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [WORD_W-1:0] req_iova_i,
  input  logic [WORD_W-1:0] req_origin_i,
  input  logic [1:0]        req_acc_i,
  input  logic [WORD_W-1:0] win_base_i,
  input  logic [WORD_W-1:0] win_limit_i,
  output logic              mem_req_o,
  output logic [WORD_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              rsp_valid_o,
  output logic [WORD_W-1:0] rsp_addr_o,
  output logic [LEN_W-1:0]  rsp_len_o,
  output logic [1:0]        rsp_perm_o,
  output logic [2:0]        rsp_err_o
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_RESP} state_e;

  state_e            state_q;
  lvl_e              lvl_q;
  logic [IOVA_W-1:0] iova_q;
  logic [1:0]        acc_q;
  logic [WORD_W-1:0] org_q;
  logic [1:0]        perm_q;
  err_e              err_q;
  logic [WORD_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;

  logic              oor;
  eval_t             ev;
  logic [1:0]        perm_nx;
  logic [1:0]        perm_fin;
  logic              acc_viol;
  logic [LEN_W-1:0]  lvl_len;

  xw_range_chk u_range (
    .iova_i (req_iova_i),
    .base_i (win_base_i),
    .limit_i(win_limit_i),
    .oor_o  (oor)
  );

  xw_index_gen #(.RX_W(RX_W), .SX_W(SX_W), .PX_W(PX_W)) u_index (
    .lvl_i    (lvl_q),
    .origin_i (org_q),
    .iova_hi_i(iova_q[IOVA_W-1:PAGE_SH]),
    .addr_o   (mem_addr_o)
  );

  xw_entry_eval #(.PAGE_SH(PAGE_SH), .SEG_SH(SEG_SH)) u_eval (
    .lvl_i  (lvl_q),
    .entry_i(mem_rdata_i),
    .low_i  (iova_q[SEG_SH-1:0]),
    .res_o  (ev)
  );

  assign perm_nx  = perm_q & (ev.prot ? PERM_RO : PERM_RW);
  assign perm_fin = (ev.kind == OUT_STOP) ? PERM_NONE : perm_nx;

  xw_access_chk u_access (
    .acc_i (acc_q),
    .perm_i(perm_fin),
    .viol_o(acc_viol)
  );

  always_comb begin
    case (lvl_q)
      LVL_REG: lvl_len = LEN_W'(REG_SH);
      LVL_SEG: lvl_len = LEN_W'(SEG_SH);
      default: lvl_len = LEN_W'(PAGE_SH);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      lvl_q   <= LVL_REG;
      iova_q  <= '0;
      acc_q   <= '0;
      org_q   <= '0;
      perm_q  <= PERM_NONE;
      err_q   <= ERR_NONE;
      addr_q  <= '0;
      len_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (req_valid_i) begin
          iova_q <= req_iova_i[IOVA_W-1:0];
          acc_q  <= req_acc_i;
          lvl_q  <= LVL_REG;
          org_q  <= {req_origin_i[WORD_W-1:ORG_SH], {ORG_SH{1'b0}}};
          addr_q <= '0;
          len_q  <= '0;
          if (oor) begin
            err_q   <= ERR_RANGE;
            perm_q  <= PERM_NONE;
            state_q <= S_RESP;
          end else begin
            err_q   <= ERR_NONE;
            perm_q  <= req_origin_i[E_PROT] ? PERM_RO : PERM_RW;
            state_q <= S_ISSUE;
          end
        end
        S_ISSUE: state_q <= S_WAIT;
        S_WAIT: if (mem_rvalid_i) begin
          len_q <= lvl_len;
          case (ev.kind)
            OUT_FAULT: begin
              err_q   <= ev.err;
              perm_q  <= PERM_NONE;
              state_q <= S_RESP;
            end
            OUT_STOP: begin
              perm_q  <= PERM_NONE;
              err_q   <= acc_viol ? ERR_PROT : ERR_NONE;
              state_q <= S_RESP;
            end
            OUT_DONE: begin
              perm_q  <= perm_nx;
              addr_q  <= ev.addr;
              err_q   <= acc_viol ? ERR_PROT : ERR_NONE;
              state_q <= S_RESP;
            end
            default: begin
              perm_q  <= perm_nx;
              org_q   <= ev.nto;
              lvl_q   <= lvl_e'(lvl_q + 2'd1);
              state_q <= S_ISSUE;
            end
          endcase
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == S_IDLE);
  assign mem_req_o   = (state_q == S_ISSUE);
  assign rsp_valid_o = (state_q == S_RESP);
  assign rsp_addr_o  = addr_q;
  assign rsp_len_o   = len_q;
  assign rsp_perm_o  = perm_q;
  assign rsp_err_o   = err_q;
endmodule

// File: rtl/xw_checker.sv
module xw_checker
  import xw_pkg::*;
#(
  parameter int unsigned LEN_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [WORD_W-1:0] req_iova_i,
  input logic [WORD_W-1:0] req_origin_i,
  input logic [1:0]        req_acc_i,
  input logic [WORD_W-1:0] win_base_i,
  input logic [WORD_W-1:0] win_limit_i,
  input logic              mem_req_o,
  input logic [WORD_W-1:0] mem_addr_o,
  input logic              rsp_valid_o,
  input logic [WORD_W-1:0] rsp_addr_o,
  input logic [LEN_W-1:0]  rsp_len_o,
  input logic [1:0]        rsp_perm_o,
  input logic [2:0]        rsp_err_o
);
  logic       accept;
  logic       oor;
  logic [1:0] acc_q;
  logic       prot_q;
  logic [2:0] reads_q;

  assign accept = req_valid_i && req_ready_o;
  assign oor    = (req_iova_i < win_base_i) || (req_iova_i > win_limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      prot_q  <= 1'b0;
      reads_q <= '0;
    end else if (accept) begin
      acc_q   <= req_acc_i;
      prot_q  <= req_origin_i[E_PROT];
      reads_q <= '0;
    end else if (mem_req_o && reads_q != 3'd7) begin
      reads_q <= reads_q + 3'd1;
    end
  end

  p_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  p_busy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o || rsp_valid_o) |-> !req_ready_o);
  p_window_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && oor) |=> (rsp_valid_o && rsp_err_o == 3'(ERR_RANGE) && rsp_perm_o == PERM_NONE && !mem_req_o));
  p_align_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[2:0] == 3'd0));
  p_reads_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (reads_q <= 3'd3));
  p_zero_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_err_o == 3'(ERR_ENTRY)) |-> (rsp_perm_o == PERM_NONE && rsp_addr_o == '0));
  p_origin_prot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && prot_q) |-> !rsp_perm_o[1]);
  p_len_code_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_err_o != 3'(ERR_RANGE)) |->
      (rsp_len_o == LEN_W'(12) || rsp_len_o == LEN_W'(20) || rsp_len_o == LEN_W'(31)));
  p_write_grant_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && acc_q == 2'd2 && rsp_err_o == 3'(ERR_NONE)) |-> rsp_perm_o[1]);
endmodule

bind dma_xlate_walker xw_checker #(.LEN_W(LEN_W)) u_xw_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_iova_i  (req_iova_i),
  .req_origin_i(req_origin_i),
  .req_acc_i   (req_acc_i),
  .win_base_i  (win_base_i),
  .win_limit_i (win_limit_i),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_addr_o  (rsp_addr_o),
  .rsp_len_o   (rsp_len_o),
  .rsp_perm_o  (rsp_perm_o),
  .rsp_err_o   (rsp_err_o)
);

// File: tb/dma_xlate_walker_bench.sv
module dma_xlate_walker_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] ROOT = 64'h0001_0000;
  localparam logic [63:0] SEGT = 64'h0020_0000;
  localparam logic [63:0] PGT  = 64'h0030_0000;
  localparam logic [63:0] BIGF = 64'h0000_00AB_CDE0_0000;
  localparam logic [63:0] PGF  = 64'h0000_0012_3456_7000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_iova = '0;
  logic [63:0] req_origin = '0;
  logic [1:0]  req_acc = '0;
  logic [63:0] win_base = '0;
  logic [63:0] win_limit = '1;
  logic        mem_req;
  logic [63:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        rsp_valid;
  logic [63:0] rsp_addr;
  logic [5:0]  rsp_len;
  logic [1:0]  rsp_perm;
  logic [2:0]  rsp_err;

  logic [63:0] mem [logic [63:0]];
  int n_chk = 0;
  int n_fail = 0;
  int rd_cnt = 0;

  dma_xlate_walker u_dma_xlate_walker (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_iova_i(req_iova), .req_origin_i(req_origin), .req_acc_i(req_acc),
    .win_base_i(win_base), .win_limit_i(win_limit),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .rsp_valid_o(rsp_valid), .rsp_addr_o(rsp_addr), .rsp_len_o(rsp_len),
    .rsp_perm_o(rsp_perm), .rsp_err_o(rsp_err)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  always @(posedge clk) begin
    mem_rvalid <= mem_req;
    mem_rdata  <= rd(mem_addr);
    if (mem_req) rd_cnt++;
  end

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] region_ent(input int v);
    case (v)
      0: return 64'd0;
      1: return SEGT | 64'h0F;
      2: return SEGT | 64'h1E;
      3: return SEGT | 64'h5F;
      4: return SEGT | 64'h1B;
      5: return 64'h1F;
      6: return SEGT | 64'h1F;
      default: return SEGT | 64'h21F;
    endcase
  endfunction

  function automatic logic [63:0] seg_ent(input int v);
    case (v)
      0: return 64'd0;
      1: return PGT | 64'h08;
      2: return PGT | 64'h1C;
      3: return 64'h18;
      4: return PGT | 64'h18;
      5: return PGT | 64'h218;
      6: return BIGF | 64'h418;
      default: return BIGF | 64'h618;
    endcase
  endfunction

  function automatic logic [63:0] page_ent(input int v);
    case (v)
      0: return 64'd0;
      1: return PGF;
      2: return 64'h10;
      3: return PGF | 64'h10;
      default: return PGF | 64'h210;
    endcase
  endfunction

  task automatic build(input logic [63:0] iova, input int rv, input int sv, input int pv);
    mem.delete();
    mem[ROOT + {53'd0, iova[41:31]} * 8] = region_ent(rv);
    mem[SEGT + {53'd0, iova[30:20]} * 8] = seg_ent(sv);
    mem[PGT  + {56'd0, iova[19:12]} * 8] = page_ent(pv);
  endtask

  task automatic run(input logic [63:0] iova, input logic oprot, input logic [1:0] acc);
    logic [63:0] e_addr, org, ent, idx;
    logic [1:0]  e_perm;
    logic [2:0]  e_err;
    logic [5:0]  e_len;
    int          e_reads, cyc;
    logic        stop, narrowed;
    string       tag;
    e_addr = 0; e_err = 0; e_len = 0; e_reads = 0; stop = 0;
    e_perm = oprot ? 2'b01 : 2'b11;
    narrowed = oprot;
    org = ROOT;
    if (iova < win_base || iova > win_limit) begin
      e_err = 1; e_perm = 0; stop = 1;
    end
    for (int lv = 0; lv < 3 && !stop; lv++) begin
      idx = (lv == 0) ? (iova >> 31) & 64'h7FF : (lv == 1) ? (iova >> 20) & 64'h7FF : (iova >> 12) & 64'hFF;
      ent = rd(org + idx * 8);
      e_reads++;
      e_len = (lv == 0) ? 6'd31 : (lv == 1) ? 6'd20 : 6'd12;
      stop = 1;
      if (ent == 0) begin e_err = 2; e_perm = 0; end
      else if (!ent[4]) e_perm = 0;
      else if (lv == 0 && (ent[1:0] != 2'b11 || ent[7:6] != 0)) begin e_err = 3; e_perm = 0; end
      else if ((lv == 0 && ent[3:2] != 2'b11) || (lv == 1 && ent[3:2] != 2'b10) || ent[63:12] == 0) begin
        e_err = 4; e_perm = 0;
      end else begin
        if (ent[9]) begin e_perm = e_perm & 2'b01; narrowed = 1; end
        if (lv == 2) e_addr = {ent[63:12], iova[11:0]};
        else if (lv == 1 && ent[10]) e_addr = {ent[63:20], iova[19:0]};
        else begin stop = 0; org = {ent[63:12], 12'd0}; end
      end
    end
    if (e_err == 0 && ((acc == 2'd1 && !e_perm[0]) || (acc == 2'd2 && !e_perm[1]))) e_err = 5;
    case (e_err)
      3'd1: tag = "R2";
      3'd2: tag = "R4";
      3'd3: tag = "R6";
      3'd4: tag = "R7";
      3'd5: tag = "R11";
      default: tag = (e_perm == 0) ? "R5" : narrowed ? "R8" : (e_len == 20) ? "R9" : "R3";
    endcase

    @(negedge clk);
    req_iova = iova; req_acc = acc;
    req_origin = ROOT | (oprot ? 64'h200 : 64'h0);
    req_valid = 1'b1;
    rd_cnt = 0;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!rsp_valid && cyc < 200) begin @(negedge clk); cyc++; end
    if (cyc >= 200) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog actual=no response expected=response");
      return;
    end
    check(tag, "err", 64'(rsp_err), 64'(e_err));
    check(tag, "perm", 64'(rsp_perm), 64'(e_perm));
    check(tag, "addr", rsp_addr, e_addr);
    check("R10", "len", 64'(rsp_len), 64'(e_len));
    check("R3", "reads", 64'(rd_cnt), 64'(e_reads));
    @(negedge clk);
    check("R1", "pulse", 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL R1 global watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] iv;
    repeat (3) @(negedge clk);
    check("R1", "reset ready", 64'(req_ready), 64'd1);
    check("R1", "reset rsp", 64'(rsp_valid), 64'd0);
    check("R1", "reset mem", 64'(mem_req), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // level variant sweep: R4..R9, R11
    iv = {22'd0, 11'd5, 11'h123, 8'h4A, 12'h5C3};
    for (int op = 0; op < 2; op++)
      for (int ac = 0; ac < 3; ac++)
        for (int r = 0; r < 8; r++)
          for (int s = 0; s < 8; s++)
            for (int p = 0; p < 5; p++) begin
              build(iv, r, s, p);
              run(iv, op[0], 2'(ac));
            end

    // index extremes: R3
    for (int k = 0; k < 4; k++) begin
      iv = (k == 0) ? 64'd0 :
           (k == 1) ? {22'd0, 11'h7FF, 11'h7FF, 8'hFF, 12'hFFF} :
           (k == 2) ? {22'd0, 11'h400, 11'h001, 8'h80, 12'h001} :
                      {22'h3F_FFFF, 11'h0AA, 11'h555, 8'h33, 12'h800};
      for (int s = 4; s < 8; s++) begin
        build(iv, 6, s, 3);
        run(iv, 1'b0, 2'd2);
      end
    end

    // window edges: R2
    win_base = 64'h1000_0000; win_limit = 64'h1FFF_FFFF;
    for (int k = 0; k < 4; k++) begin
      iv = (k == 0) ? win_base - 1 : (k == 1) ? win_base : (k == 2) ? win_limit : win_limit + 1;
      build(iv, 6, 4, 3);
      run(iv, 1'b0, 2'd1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule